// File: doc/BRIEF.md
# Vertical Format Table Loader

This block builds the vertical format table of a line printer controller from a byte stream. Bytes arrive with a valid strobe next to a function code. Only while that code selects the format-load function do bytes have any effect. A start code opens a load. After that, pairs of data bytes each give one 12-bit channel word: the low six bits of each byte fill one half of the word. A stop code writes an end-of-form marker and closes the load. On closing, the block checks the table and decides whether the format unit may go online.

The 256-entry, 13-bit table is held inside the block. Each table write is also shown on a write-access output group in the same cycle that it takes effect. A second, read-only port is addressed by line number and returns the stored word without delay, for use by the vertical skip logic. A not-ready flag is raised by reset and dropped by the first start code.

Top module: `vfmt_loader`

## Requirements
- R1: After reset the online flag is 0, the not-ready flag is 1 and every table entry reads 0.
- R2: With function code 2 (format load), a valid byte of 0xEC, 0xED or 0xEE opens a load. It sets the entry index to 0, selects the first half and clears the not-ready flag.
- R3: While a load is open, the first data byte of a pair writes its bits 5:0 into entry bits 5:0, and the second writes its bits 5:0 into entry bits 11:6. Each such write keeps the other half of the entry and clears bit 12. The index advances by one after the second byte only.
- R4: With function code 2, a valid byte 0xEF writes 0x1000 (only bit 12 set) at the current index, whether or not a load is open, and leaves the loading state.
- R5: On a 0xEF byte, the online flag becomes 1 if no half pair is pending and at least 12 entries have been completed; otherwise it becomes 0.
- R6: If the function code differs from 2 in any cycle while a load is open, the load is abandoned and the online flag is cleared; later data bytes write nothing until a new start code.
- R7: Bytes presented with a function code other than 2, and data bytes (not 0xEC to 0xEF) arriving while no load is open, cause no table write and change no flag.
- R8: Once 256 entries are complete, further data writes and the stop marker are dropped. The index stays past the last entry, so a stop with no pending half sets the online flag.
- R9: The read port returns, in the same cycle, the entry selected by the line number input.
- R10: The not-ready flag is set only by reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| func | input | 2 | Controller function code; 2 selects format load |
| byte_vld | input | 1 | Byte strobe |
| byte_dat | input | 8 | Stream byte |
| rd_line | input | 8 | Line number for the read port |
| rd_word | output | 13 | Table entry at rd_line |
| wr_en | output | 1 | A table write takes effect at the next edge |
| wr_addr | output | 8 | Entry being written |
| wr_data | output | 13 | Word being written |
| fmt_online | output | 1 | Format unit online |
| fmt_not_ready | output | 1 | Format unit not ready |

## Verification
Most internal faults in this block first show up at the write-access outputs, in the same cycle as the byte that triggers them. A wrong index shows as a wrong wr_addr, a wrong half-select as a wrong field in wr_data, and a stale loading state as a write that should not be there. A miscounted pair or a wrong completeness threshold shows at the online flag one edge after the stop code. Sweeping the read port after each phase of the test shows any write that reached the wrong entry, or that should have been dropped after the table filled up.

// File: rtl/vfmt_loader.sv
module vfmt_loader #(
  parameter int DEPTH     = 256,
  parameter int HALF_W    = 6,
  parameter int BYTE_W    = 8,
  parameter int FUNC_W    = 2,
  parameter int LOAD_FUNC = 2,
  parameter int MIN_LINES = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [FUNC_W-1:0]         func,
  input  logic                      byte_vld,
  input  logic [BYTE_W-1:0]         byte_dat,
  input  logic [$clog2(DEPTH)-1:0]  rd_line,
  output logic [2*HALF_W:0]         rd_word,
  output logic                      wr_en,
  output logic [$clog2(DEPTH)-1:0]  wr_addr,
  output logic [2*HALF_W:0]         wr_data,
  output logic                      fmt_online,
  output logic                      fmt_not_ready
);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = IDX_W + 1;
  localparam int WORD_W = 2*HALF_W + 1;
  localparam logic [BYTE_W-1:0] START_LO  = BYTE_W'(8'hEC);
  localparam logic [BYTE_W-1:0] START_HI  = BYTE_W'(8'hEE);
  localparam logic [BYTE_W-1:0] STOP_CODE = BYTE_W'(8'hEF);
  localparam logic [WORD_W-1:0] EOF_WORD  = WORD_W'(1) << (WORD_W-1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic              loading, phase;
  logic [CNT_W-1:0]  idx;

  wire in_fn    = (func == FUNC_W'(LOAD_FUNC));
  wire take     = byte_vld && in_fn;
  wire is_start = (byte_dat >= START_LO) && (byte_dat <= START_HI);
  wire is_stop  = (byte_dat == STOP_CODE);
  wire room     = (idx < CNT_W'(DEPTH));
  wire [IDX_W-1:0]  cur = idx[IDX_W-1:0];
  wire [WORD_W-1:0] old = mem[cur];

  assign rd_word = mem[rd_line];
  assign wr_addr = cur;

  always_comb begin
    wr_en   = 1'b0;
    wr_data = '0;
    if (take && !is_start && room) begin
      if (is_stop) begin
        wr_en   = 1'b1;
        wr_data = EOF_WORD;
      end else if (loading) begin
        wr_en   = 1'b1;
        wr_data = phase ? {1'b0, byte_dat[HALF_W-1:0], old[HALF_W-1:0]}
                        : {1'b0, old[2*HALF_W-1:HALF_W], byte_dat[HALF_W-1:0]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading       <= 1'b0;
      phase         <= 1'b0;
      idx           <= '0;
      fmt_online    <= 1'b0;
      fmt_not_ready <= 1'b1;
    end else if (take) begin
      if (is_start) begin
        loading       <= 1'b1;
        phase         <= 1'b0;
        idx           <= '0;
        fmt_not_ready <= 1'b0;
      end else if (is_stop) begin
        loading    <= 1'b0;
        fmt_online <= !phase && (idx >= CNT_W'(MIN_LINES));
      end else if (loading) begin
        phase <= ~phase;
        if (phase && room) idx <= idx + 1'b1;
      end
    end else if (loading && !in_fn) begin
      loading    <= 1'b0;
      fmt_online <= 1'b0;
    end
  end
endmodule

module vfmt_loader_chk #(
  parameter int FUNC_W    = 2,
  parameter int LOAD_FUNC = 2,
  parameter int WORD_W    = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic [FUNC_W-1:0] func,
  input logic              byte_vld,
  input logic [7:0]        byte_dat,
  input logic              wr_en,
  input logic [WORD_W-1:0] wr_data,
  input logic              fmt_online,
  input logic              fmt_not_ready,
  input logic              loading
);
  wire load_fn = (func == FUNC_W'(LOAD_FUNC));
  wire start_b = byte_vld && load_fn && byte_dat >= 8'hEC && byte_dat <= 8'hEE;
  wire stop_b  = byte_vld && load_fn && byte_dat == 8'hEF;

  p_start_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_b |=> !fmt_not_ready);

  p_half_clears_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stop_b) |-> !wr_data[WORD_W-1]);

  p_marker_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && stop_b) |-> wr_data == (WORD_W'(1) << (WORD_W-1)));

  p_online_from_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_b |=> !$rose(fmt_online));

  p_abandon_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (loading && !load_fn) |=> (!fmt_online && !loading));

  p_no_write_off_fn_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load_fn |-> !wr_en);

  p_ready_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !fmt_not_ready |=> !fmt_not_ready);
endmodule

bind vfmt_loader vfmt_loader_chk #(.FUNC_W(FUNC_W), .LOAD_FUNC(LOAD_FUNC), .WORD_W(2*HALF_W+1)) u_chk (
  .clk(clk), .rst_n(rst_n), .func(func), .byte_vld(byte_vld), .byte_dat(byte_dat),
  .wr_en(wr_en), .wr_data(wr_data), .fmt_online(fmt_online),
  .fmt_not_ready(fmt_not_ready), .loading(loading));

// File: tb/tb_vfmt_loader.sv
module tb_vfmt_loader;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  func = 2'd0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_dat = 8'd0;
  logic [7:0]  rd_line = 8'd0;
  logic [12:0] rd_word, wr_data;
  logic        wr_en, fmt_online, fmt_not_ready;
  logic [7:0]  wr_addr;

  vfmt_loader dut (
    .clk(clk), .rst_n(rst_n), .func(func), .byte_vld(byte_vld), .byte_dat(byte_dat),
    .rd_line(rd_line), .rd_word(rd_word), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fmt_online(fmt_online), .fmt_not_ready(fmt_not_ready));

  always #(CLK_NS/2) clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [12:0] m_mem [256];
  bit m_load, m_phase, m_on, m_nr;
  int m_idx;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] half_word(input logic [12:0] old, input logic [7:0] b, input bit second);
    return second ? {1'b0, b[5:0], old[5:0]} : {1'b0, old[11:6], b[5:0]};
  endfunction

  function automatic bit is_start(input logic [7:0] b);
    return b == 8'hEC || b == 8'hED || b == 8'hEE;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 256; i++) m_mem[i] = '0;
    m_load = 0; m_phase = 0; m_on = 0; m_nr = 1; m_idx = 0;
  endtask

  task automatic send(input logic [1:0] f, input logic [7:0] b, input string req);
    bit ew; logic [7:0] ea; logic [12:0] ed;
    ew = 0; ea = m_idx[7:0]; ed = '0;
    if (f == 2'd2 && !is_start(b) && m_idx < 256) begin
      if (b == 8'hEF) begin ew = 1; ed = 13'h1000; end
      else if (m_load) begin ew = 1; ed = half_word(m_mem[m_idx], b, m_phase); end
    end
    @(negedge clk);
    func = f; byte_vld = 1'b1; byte_dat = b;
    #1;
    chk(wr_en == ew, {req, " wr_en"}, wr_en, ew);
    if (ew) chk({wr_addr, wr_data} == {ea, ed}, {req, " write"}, {wr_addr, wr_data}, {ea, ed});
    if (ew) m_mem[ea] = ed;
    if (f == 2'd2) begin
      if (is_start(b)) begin m_load = 1; m_idx = 0; m_phase = 0; m_nr = 0; end
      else if (b == 8'hEF) begin m_load = 0; m_on = !m_phase && m_idx >= 12; end
      else if (m_load) begin
        if (m_phase && m_idx < 256) m_idx++;
        m_phase = !m_phase;
      end
    end else if (m_load) begin
      m_load = 0; m_on = 0;
    end
    @(negedge clk);
    byte_vld = 1'b0;
    chk(fmt_online == m_on, {req, " online"}, fmt_online, m_on);
    chk(fmt_not_ready == m_nr, "R10 not_ready", fmt_not_ready, m_nr);
  endtask

  task automatic idle(input logic [1:0] f, input string req);
    @(negedge clk);
    func = f;
    if (f != 2'd2 && m_load) begin m_load = 0; m_on = 0; end
    @(negedge clk);
    chk(fmt_online == m_on, {req, " online"}, fmt_online, m_on);
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 256; i++) begin
      rd_line = i[7:0];
      #1;
      chk(rd_word == m_mem[i], req, rd_word, m_mem[i]);
    end
  endtask

  task automatic pairs(input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      send(2'd2, 8'((i * 37 + seed) & 8'h3F), "R3 first half");
      send(2'd2, 8'((i * 11 + seed + 5) & 8'h3F) | 8'h40, "R3 second half");
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_NS * 190000);
    bad++; total++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    summary();
  end

  initial begin
    void'($urandom(32'd20240601));
    model_reset();
    repeat (3) @(negedge clk);
    chk(fmt_online == 1'b0, "R1 online at reset", fmt_online, 0);
    chk(fmt_not_ready == 1'b1, "R1 not_ready at reset", fmt_not_ready, 1);
    rst_n = 1'b1;
    sweep("R1 table clear");

    send(2'd2, 8'h15, "R7 data before start");
    send(2'd1, 8'hEC, "R7 start with wrong func");
    chk(fmt_not_ready == 1'b1, "R7 wrong func start ignored", fmt_not_ready, 1);

    send(2'd2, 8'hED, "R2 start");
    pairs(12, 3);
    send(2'd2, 8'hEF, "R4 stop after 12");
    chk(fmt_online == 1'b1, "R5 twelve lines online", fmt_online, 1);
    sweep("R3 R9 table after 12");

    send(2'd2, 8'hEE, "R2 start 0xEE");
    pairs(11, 9);
    send(2'd2, 8'hEF, "R5 stop after 11");
    chk(fmt_online == 1'b0, "R5 eleven lines offline", fmt_online, 0);

    send(2'd2, 8'hEC, "R2 start 0xEC");
    pairs(13, 1);
    send(2'd2, 8'h2A, "R3 dangling half");
    send(2'd2, 8'hEF, "R5 stop dangling");
    chk(fmt_online == 1'b0, "R5 dangling half offline", fmt_online, 0);

    send(2'd2, 8'hEC, "R2 restart");
    pairs(12, 4);
    send(2'd2, 8'hEF, "R5 online again");
    send(2'd2, 8'hEC, "R2 start before abandon");
    pairs(3, 6);
    idle(2'd0, "R6 func change");
    chk(fmt_online == 1'b0, "R6 abandon clears online", fmt_online, 0);
    send(2'd2, 8'h33, "R6 data after abandon");
    send(2'd2, 8'h21, "R6 data after abandon");
    sweep("R6 R7 table unchanged");

    send(2'd2, 8'hED, "R8 start");
    pairs(260, 2);
    send(2'd2, 8'hEF, "R8 stop when full");
    chk(fmt_online == 1'b1, "R8 full table online", fmt_online, 1);
    sweep("R8 table full");

    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [1:0] f;
      logic [7:0] b;
      r = $urandom_range(0, 99);
      f = (r < 3) ? 2'($urandom_range(0, 3)) : 2'd2;
      r = $urandom_range(0, 99);
      if (r < 6) b = 8'hEC + 8'($urandom_range(0, 2));
      else if (r < 10) b = 8'hEF;
      else b = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 49) == 0) idle(2'($urandom_range(0, 3)), "R6 random idle");
      else send(f, b, "R3 R4 R5 random");
    end
    sweep("R9 final table");

    summary();
  end
endmodule